// File: doc/BRIEF.md
# Message-to-Level Interrupt Aggregator

This block gathers message-signalled interrupts for 32 vectors and presents them to a parent interrupt controller as one level-sensitive request line. Each message arrives as a one-cycle strobe with a 5-bit vector index. The message sets a sticky pending latch for that vector. The latch holds until software clears it, so a message that arrives while the line is already high is never lost.

Software reads the 32-bit pending word to see which vectors need service. Bit n of that word belongs to vector n. Software clears vectors by writing a mask in which every 1 bit releases the matching latch. The request line stays high for as long as any latch is set.

Top module: `msi_level_agg`

## Requirements
- R1: A synchronous reset clears all 32 pending bits and drives `irq_level` low on the next clock edge.
- R2: When `msg_valid` is high with `msg_vec` = n at a clock edge, bit n of `status` reads 1 after that edge.
- R3: A pending bit stays set, across any number of cycles and any later messages, until a write to `ack_data` has a 1 in its position.
- R4: A write with `ack_we` high clears every pending bit whose `ack_data` bit is 1 and leaves bits written as 0 unchanged.
- R5: When a message for vector n and an acknowledge with bit n set occur at the same edge, bit n is still 1 afterwards.
- R6: A second message for a vector that is already pending leaves it as one pending bit, and a single acknowledge of that bit clears it.
- R7: `irq_level` is registered. After each edge it equals the OR of the `status` value seen before that edge. It is high while any bit is set and low only one cycle after all bits are clear.
- R8: `status` is a side-effect-free view of the latches. It does not change in a cycle with neither a valid message nor an acknowledge write.
- R9: While `msg_valid` is low, the value on `msg_vec` has no effect on `status`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | Message strobe, one event per high cycle |
| msg_vec | input | 5 | Vector index carried by the message |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_data | input | 32 | Write-one-to-clear mask for the pending bits |
| status | output | 32 | Current pending bits, bit n for vector n |
| irq_level | output | 1 | Level request toward the parent controller |

## Verification
A message and an acknowledge can land in the same cycle, either on the same vector or on different ones. The bench provokes this on purpose: it sends a message for vector n together with an acknowledge mask that includes bit n. It also mixes the two in a long pseudo-random run where both strobes are often active at once. A behavioural reference model applies clear-then-set on every edge and predicts the registered level line. The model is compared against `status` and `irq_level` on every clock, so a clear that wins, or a bystander bit that gets disturbed, shows up as a miscompare.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
    parameter int VEC_CNT = 32;
    localparam int VEC_W = $clog2(VEC_CNT);

    typedef logic [VEC_CNT-1:0] vec_mask_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] idx;
    } msg_t;
endpackage

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
    parameter int N = 32,
    localparam int W = $clog2(N)
) (
    input  logic         valid,
    input  logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign onehot[i] = valid && (idx == W'(i));
    end
endmodule

// File: rtl/msi_latch_bank.sv
module msi_latch_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_mask,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] pend
);
    typedef struct packed {
        logic [N-1:0] pend;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.pend = st_d.pend & ~clr_mask;
        end
        // set applied after clear: a fresh event beats a same-cycle acknowledge
        st_d.pend = st_d.pend | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/msi_level_out.sv
module msi_level_out #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    output logic         level
);
    typedef struct packed {
        logic lvl;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = |pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;
endmodule

// File: rtl/msi_level_agg.sv
module msi_level_agg
    import msi_agg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   msg_valid,
    input  logic [VEC_W-1:0]       msg_vec,
    input  logic                   ack_we,
    input  logic [VEC_CNT-1:0]     ack_data,
    output logic [VEC_CNT-1:0]     status,
    output logic                   irq_level
);
    msg_t      msg;
    vec_mask_t set_mask;
    vec_mask_t pend;

    assign msg.valid = msg_valid;
    assign msg.idx   = msg_vec;

    msi_vec_decode #(.N(VEC_CNT)) u_dec (
        .valid  (msg.valid),
        .idx    (msg.idx),
        .onehot (set_mask)
    );

    msi_latch_bank #(.N(VEC_CNT)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_en   (ack_we),
        .clr_mask (ack_data),
        .pend     (pend)
    );

    msi_level_out #(.N(VEC_CNT)) u_lvl (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend),
        .level (irq_level)
    );

    assign status = pend;
endmodule

// File: rtl/msi_level_agg_chk.sv
module msi_level_agg_chk
    import msi_agg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               msg_valid,
    input logic [VEC_W-1:0]   msg_vec,
    input logic               ack_we,
    input logic [VEC_CNT-1:0] ack_data,
    input logic [VEC_CNT-1:0] status,
    input logic               irq_level
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (status == '0) && !irq_level);

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> status[$past(msg_vec)]);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ack_we |=> ((status & $past(status)) == $past(status)));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_we && !msg_valid) |=> status == ($past(status) & ~$past(ack_data)));

    assert_level_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_level == $past(|status));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && !ack_we) |=> $stable(status));
endmodule

bind msi_level_agg msi_level_agg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_vec   (msg_vec),
    .ack_we    (ack_we),
    .ack_data  (ack_data),
    .status    (status),
    .irq_level (irq_level)
);

// File: tb/msi_level_agg_tb.sv
module msi_level_agg_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        msg_valid;
    logic [4:0]  msg_vec;
    logic        ack_we;
    logic [31:0] ack_data;
    logic [31:0] status;
    logic        irq_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit ref_pend [32];
    bit ref_irq;

    always #2.5 clk = ~clk;

    msi_level_agg u_dut (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_vec(msg_vec),
        .ack_we(ack_we), .ack_data(ack_data), .status(status), .irq_level(irq_level)
    );

    function automatic logic [31:0] ref_word();
        logic [31:0] w;
        for (int i = 0; i < 32; i++) w[i] = ref_pend[i];
        return w;
    endfunction

    task automatic compare(string req);
        checks++;
        if (status !== ref_word()) begin
            fails++;
            $display("FAIL %s status actual=%h expected=%h", req, status, ref_word());
        end
        checks++;
        if (irq_level !== ref_irq) begin
            fails++;
            $display("FAIL %s irq_level actual=%b expected=%b", req, irq_level, ref_irq);
        end
    endtask

    // drive at negedge, update model at posedge, compare at next negedge
    task automatic step(bit v, int vec, bit we, logic [31:0] mask, string req);
        bit any;
        msg_valid = v;
        msg_vec   = 5'(vec);
        ack_we    = we;
        ack_data  = mask;
        @(posedge clk);
        any = 0;
        for (int i = 0; i < 32; i++) any |= ref_pend[i];
        ref_irq = any;
        if (we) for (int i = 0; i < 32; i++) if (mask[i]) ref_pend[i] = 0;
        if (v) ref_pend[vec] = 1;
        @(negedge clk);
        compare(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_1234;
        rst = 1; msg_valid = 0; msg_vec = 0; ack_we = 0; ack_data = 0;
        for (int i = 0; i < 32; i++) ref_pend[i] = 0;
        ref_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst = 0;

        step(0, 0, 0, 0, "R8");
        step(1, 0, 0, 0, "R2");              // vector 0
        step(0, 0, 0, 0, "R7");              // level rises one cycle later
        step(1, 31, 0, 0, "R2");             // top vector
        step(0, 9, 0, 0, "R9");              // strobe low, index ignored
        step(0, 17, 0, 0, "R9");
        repeat (4) step(0, 0, 0, 0, "R3");
        step(1, 5, 0, 0, "R3");
        step(1, 5, 0, 0, "R6");              // duplicate merges
        step(0, 0, 1, 32'h0000_0000, "R4");  // zero mask clears nothing
        step(0, 0, 1, 32'h0000_0020, "R6");  // one ack clears vector 5
        step(0, 0, 1, 32'h8000_0000, "R4");  // clear 31, keep 0
        step(1, 12, 1, 32'h0000_1000, "R5"); // set and ack same vector
        step(1, 3, 1, 32'h0000_1001, "R5");  // different vector set, others cleared
        step(0, 0, 1, 32'hFFFF_FFFF, "R4");
        step(0, 0, 0, 0, "R7");              // level falls one cycle after clear
        step(0, 0, 0, 0, "R7");

        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3], int'(lfsr[8:4]), lfsr[12] & lfsr[13],
                 lfsr ^ {lfsr[15:0], lfsr[31:16]}, "R5");
        end

        rst = 1;
        @(posedge clk);
        for (int i = 0; i < 32; i++) ref_pend[i] = 0;
        ref_irq = 0;
        @(negedge clk);
        compare("R1");
        finish_run();
    end
endmodule